// File: doc/BRIEF.md
# ECC Error Capture Log

This block keeps a record of the first ECC error seen on a bus where each transaction has two address halves, an attribute phase and a data phase. Each cycle it can receive one error event from the bus checker. The event carries a valid strobe, a flag that says whether the error is correctable or uncorrectable, the phase kind, a data-width flag and an 8-bit syndrome. A separate input tells the block whether hardware correction is currently turned off.

The first event is written into a status record. The record holds a phase code, a corrected flag and the syndrome, and it then stays locked. Later events cannot overwrite it. They can only raise a sticky overflow flag, and only when they belong to the uncorrectable class. Software reads the record through a small register port. Writing ones to the phase field unlocks the record so that the next error can be captured. Writing a one to the overflow bit clears that flag.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, the status word reads zero.
- R2: On capture, the phase field (bits 6:4) is set from the event kind and width. Address low half gives 1, address high half gives 2, attribute gives 3, 32-bit data gives 4 and 64-bit data gives 5. Kind inputs are coded 0 = address low, 1 = address high, 2 = attribute, 3 = data, and the width flag 1 means 64-bit. Codes 6 and 7 never appear.
- R3: An event is captured only while the phase field is zero. While the field is non-zero, later events leave the phase, corrected flag and syndrome unchanged.
- R4: A register write to the status address with any of bits 6:4 set to one returns the phase, corrected flag and syndrome fields to zero. A write with bits 6:4 all zero leaves them unchanged.
- R5: On capture, the corrected flag (bit 7) is 1 only when the event was correctable and correction was enabled. In every other case it is 0.
- R6: The captured syndrome sits in bits 15:8. For a 32-bit data error, bit 15 is forced to 0. For other phases all 8 bits are kept.
- R7: The overflow flag (bit 3) is set when an event arrives while the phase field is non-zero and the event is uncorrectable or correction is disabled. A correctable event that arrives with correction enabled while the record is locked changes nothing.
- R8: The overflow flag is sticky. Clearing the phase field does not clear it. It is cleared by writing 1 to bit 3, and a set in the same cycle wins over that clear.
- R9: If an event arrives in the same cycle as a phase-clearing write, the event is dropped. It neither captures nor sets the overflow flag.
- R10: Reads are combinational from the address. Any other address reads zero, and bits 31:16 and 2:0 of the status word read zero. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Error event present this cycle |
| evt_uncorr_i | input | 1 | 1 = uncorrectable, 0 = correctable |
| evt_kind_i | input | 2 | Phase kind: 0 addr low, 1 addr high, 2 attribute, 3 data |
| evt_wide_i | input | 1 | Data phase is 64-bit |
| evt_syn_i | input | 8 | Syndrome bits E0..E7 |
| corr_dis_i | input | 1 | Hardware correction disabled |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data |

## Verification
The bench targets three cases: an error that arrives while the record is locked, an event that coincides with a software clear, and a set of the overflow flag that coincides with its own clear.
- A design that does not lock would show the syndrome or phase of the second error.
- A design that lets the event win the clear race would come out locked or with overflow raised.
- A design that lets the overflow clear win would lose an uncorrectable error.

The bench also checks several other outputs:
- the corrected flag under disabled correction;
- the forced-zero bit 15 for narrow data errors;
- a locked correctable error that must not raise overflow;
- write data with bits 6:4 zero, which must not unlock.

A design that got any of these wrong would report a wrong status word.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

  localparam int SYN_W    = 8;
  localparam int PH_W     = 3;
  localparam int SYN_LSB  = 8;
  localparam int CORR_BIT = 7;
  localparam int PH_LSB   = 4;
  localparam int OVF_BIT  = 3;
  localparam int WORD_MSB = SYN_LSB + SYN_W - 1;

  typedef enum logic [1:0] {
    KIND_ADDR_LO = 2'd0,
    KIND_ADDR_HI = 2'd1,
    KIND_ATTR    = 2'd2,
    KIND_DATA    = 2'd3
  } evt_kind_e;

  typedef enum logic [PH_W-1:0] {
    PH_NONE    = 3'd0,
    PH_ADDR_LO = 3'd1,
    PH_ADDR_HI = 3'd2,
    PH_ATTR    = 3'd3,
    PH_DATA32  = 3'd4,
    PH_DATA64  = 3'd5
  } phase_e;

  typedef struct packed {
    logic [SYN_W-1:0] syn;
    logic             corr;
    logic [PH_W-1:0]  phase;
    logic             ovf;
  } rec_t;

endpackage

// File: rtl/ecc_phase_enc.sv
module ecc_phase_enc
  import ecc_log_pkg::*;
(
  input  logic [1:0]       kind_i,
  input  logic             wide_i,
  input  logic [SYN_W-1:0] syn_i,
  output logic [PH_W-1:0]  phase_o,
  output logic [SYN_W-1:0] syn_o
);

  always_comb begin
    phase_o = PH_NONE;
    syn_o   = syn_i;
    unique case (kind_i)
      KIND_ADDR_LO: phase_o = PH_ADDR_LO;
      KIND_ADDR_HI: phase_o = PH_ADDR_HI;
      KIND_ATTR:    phase_o = PH_ATTR;
      default: begin
        if (wide_i) begin
          phase_o = PH_DATA64;
        end else begin
          phase_o = PH_DATA32;
          // narrow data uses a 7-bit check code: top syndrome bit is zero
          syn_o[SYN_W-1] = 1'b0;
        end
      end
    endcase
  end

endmodule

// File: rtl/ecc_capture_ctl.sv
module ecc_capture_ctl
  import ecc_log_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             uncorr_i,
  input  logic             corr_dis_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic [SYN_W-1:0] syn_i,
  input  logic             clr_phase_i,
  input  logic             clr_ovf_i,
  output rec_t             rec_o
);

  rec_t rec_q;
  logic locked, hard, take, ovf_set;

  assign locked  = (rec_q.phase != PH_NONE);
  assign hard    = uncorr_i | corr_dis_i;
  // a clear in the same cycle drops the event entirely
  assign take    = valid_i & ~locked & ~clr_phase_i;
  assign ovf_set = valid_i & locked & hard & ~clr_phase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q <= '0;
    end else begin
      if (clr_phase_i) begin
        rec_q.phase <= PH_NONE;
        rec_q.corr  <= 1'b0;
        rec_q.syn   <= '0;
      end else if (take) begin
        rec_q.phase <= phase_i;
        rec_q.corr  <= ~hard;
        rec_q.syn   <= syn_i;
      end
      if (ovf_set)        rec_q.ovf <= 1'b1;
      else if (clr_ovf_i) rec_q.ovf <= 1'b0;
    end
  end

  assign rec_o = rec_q;

endmodule

// File: rtl/ecc_reg_if.sv
module ecc_reg_if
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h10
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  rec_t              rec_i,
  output logic              clr_phase_o,
  output logic              clr_ovf_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              hit;
  logic [DATA_W-1:0] word;
  logic              unused_wdata;

  assign hit          = (addr_i == STAT_ADDR);
  assign clr_phase_o  = wr_i & hit & (|wdata_i[PH_LSB +: PH_W]);
  assign clr_ovf_o    = wr_i & hit & wdata_i[OVF_BIT];
  assign unused_wdata = ^{wdata_i[DATA_W-1:CORR_BIT], wdata_i[OVF_BIT-1:0]};

  always_comb begin
    word                     = '0;
    word[SYN_LSB +: SYN_W]   = rec_i.syn;
    word[CORR_BIT]           = rec_i.corr;
    word[PH_LSB +: PH_W]     = rec_i.phase;
    word[OVF_BIT]            = rec_i.ovf;
    rdata_o                  = hit ? word : '0;
  end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic              evt_uncorr_i,
  input  logic [1:0]        evt_kind_i,
  input  logic              evt_wide_i,
  input  logic [7:0]        evt_syn_i,
  input  logic              corr_dis_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);

  logic [PH_W-1:0]  enc_phase;
  logic [SYN_W-1:0] enc_syn;
  logic             clr_phase, clr_ovf;
  rec_t             rec;

  ecc_phase_enc u_enc (
    .kind_i  (evt_kind_i),
    .wide_i  (evt_wide_i),
    .syn_i   (evt_syn_i),
    .phase_o (enc_phase),
    .syn_o   (enc_syn)
  );

  ecc_capture_ctl u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (evt_valid_i),
    .uncorr_i    (evt_uncorr_i),
    .corr_dis_i  (corr_dis_i),
    .phase_i     (enc_phase),
    .syn_i       (enc_syn),
    .clr_phase_i (clr_phase),
    .clr_ovf_i   (clr_ovf),
    .rec_o       (rec)
  );

  ecc_reg_if #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .STAT_ADDR (STAT_ADDR)
  ) u_reg (
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rec_i       (rec),
    .clr_phase_o (clr_phase),
    .clr_ovf_o   (clr_ovf),
    .rdata_o     (reg_rdata_o)
  );

endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_valid_i,
  input logic              evt_uncorr_i,
  input logic              corr_dis_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input rec_t              rec_i
);

  logic hit_w, clr_ph, clr_ov;
  assign hit_w  = reg_wr_i && (reg_addr_i == STAT_ADDR);
  assign clr_ph = hit_w && (|reg_wdata_i[6:4]);
  assign clr_ov = hit_w && reg_wdata_i[3];

  AST_PHASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i.phase <= 3'd5); // R2

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_i.phase != 3'd0 && !clr_ph) |=>
      ($stable(rec_i.phase) && $stable(rec_i.syn) && $stable(rec_i.corr))); // R3

  AST_PHASE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ph |=> (rec_i.phase == 3'd0)); // R4

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ph && evt_valid_i && !rec_i.ovf && !clr_ov) |=> (rec_i.phase == 3'd0 && !rec_i.ovf)); // R9

  AST_CORR_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && rec_i.phase == 3'd0 && !clr_ph) |=>
      (rec_i.corr == !($past(evt_uncorr_i) || $past(corr_dis_i)))); // R5

  AST_SYN_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_i.phase == 3'd4) |-> !rec_i.syn[7]); // R6

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && rec_i.phase != 3'd0 && !clr_ph && (evt_uncorr_i || corr_dis_i)) |=> rec_i.ovf); // R7

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_i.ovf && !clr_ov) |=> rec_i.ovf); // R8

  AST_READ_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i != STAT_ADDR) |-> (reg_rdata_o == '0)); // R10

  AST_READ_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[DATA_W-1:16] == '0) && (reg_rdata_o[2:0] == 3'd0)); // R10

endmodule

bind ecc_err_log ecc_err_log_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .STAT_ADDR (STAT_ADDR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_valid_i  (evt_valid_i),
  .evt_uncorr_i (evt_uncorr_i),
  .corr_dis_i   (corr_dis_i),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .rec_i        (rec)
);

// File: tb/ecc_err_log_test.sv
module ecc_err_log_test;

  localparam logic [7:0] STAT = 8'h10;
  localparam logic [7:0] OTHER = 8'h14;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ev_valid = 1'b0, ev_uncorr = 1'b0, ev_wide = 1'b0, corr_dis = 1'b0;
  logic [1:0]  ev_kind = 2'd0;
  logic [7:0]  ev_syn = 8'h00;
  logic        wr = 1'b0;
  logic [7:0]  addr = STAT;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  ecc_err_log #(.ADDR_W(8), .DATA_W(32), .STAT_ADDR(STAT)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .evt_valid_i(ev_valid), .evt_uncorr_i(ev_uncorr), .evt_kind_i(ev_kind),
    .evt_wide_i(ev_wide), .evt_syn_i(ev_syn), .corr_dis_i(corr_dis),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  function automatic logic [31:0] w(input logic [7:0] syn, input logic corr,
                                    input logic [2:0] ph, input logic ovf);
    return {16'h0, syn, corr, ph, ovf, 3'b000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(output logic [31:0] v);
    addr = STAT;
    #1 v = rdata;
  endtask

  // one cycle of stimulus; outputs checked at the following falling edge
  task automatic cyc(input logic ev, input logic [1:0] k, input logic wide, input logic unc,
                     input logic [7:0] syn, input logic dowr, input logic [7:0] a,
                     input logic [31:0] wd);
    @(negedge clk);
    ev_valid = ev; ev_kind = k; ev_wide = wide; ev_uncorr = unc; ev_syn = syn;
    wr = dowr; addr = a; wdata = wd;
    @(negedge clk);
    ev_valid = 1'b0; wr = 1'b0; addr = STAT; wdata = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(v); chk("R1 reset word", v, 32'h0);
  endtask

  task automatic t_encode();
    logic [31:0] v;
    cyc(1, 2'd0, 0, 0, 8'hA5, 0, STAT, 0); rd(v); chk("R2 addr low", v, w(8'hA5, 1, 3'd1, 0));
    cyc(0, 0, 0, 0, 0, 1, STAT, 32'h70);   rd(v); chk("R4 clear all bits", v, 32'h0);
    cyc(1, 2'd1, 0, 0, 8'h3C, 0, STAT, 0); rd(v); chk("R2 addr high", v, w(8'h3C, 1, 3'd2, 0));
    cyc(0, 0, 0, 0, 0, 1, STAT, 32'h70);
    cyc(1, 2'd2, 1, 0, 8'h81, 0, STAT, 0); rd(v); chk("R2 attribute", v, w(8'h81, 1, 3'd3, 0));
    cyc(0, 0, 0, 0, 0, 1, STAT, 32'h70);
    cyc(1, 2'd3, 0, 0, 8'hA5, 0, STAT, 0); rd(v); chk("R6 data32 bit15 zero", v, w(8'h25, 1, 3'd4, 0));
    cyc(0, 0, 0, 0, 0, 1, STAT, 32'h70);
    cyc(1, 2'd3, 1, 0, 8'hA5, 0, STAT, 0); rd(v); chk("R6 data64 full syndrome", v, w(8'hA5, 1, 3'd5, 0));
    cyc(0, 0, 0, 0, 0, 1, STAT, 32'h70);
  endtask

  task automatic t_corrected();
    logic [31:0] v;
    cyc(1, 2'd0, 0, 1, 8'h11, 0, STAT, 0); rd(v); chk("R5 uncorrectable not corrected", v, w(8'h11, 0, 3'd1, 0));
    cyc(0, 0, 0, 0, 0, 1, STAT, 32'h70);
    corr_dis = 1'b1;
    cyc(1, 2'd2, 0, 0, 8'h22, 0, STAT, 0); rd(v); chk("R5 correction disabled", v, w(8'h22, 0, 3'd3, 0));
    corr_dis = 1'b0;
    cyc(0, 0, 0, 0, 0, 1, STAT, 32'h70);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    cyc(1, 2'd1, 0, 0, 8'h5A, 0, STAT, 0);
    cyc(1, 2'd3, 1, 0, 8'hFF, 0, STAT, 0); rd(v); chk("R3 R7 locked correctable ignored", v, w(8'h5A, 1, 3'd2, 0));
    cyc(1, 2'd0, 0, 1, 8'h77, 0, STAT, 0); rd(v); chk("R7 locked uncorrectable sets ovf", v, w(8'h5A, 1, 3'd2, 1));
    cyc(0, 0, 0, 0, 0, 1, STAT, 32'h87);   rd(v); chk("R4 write without phase bits", v, w(8'h5A, 1, 3'd2, 1));
    cyc(0, 0, 0, 0, 0, 1, STAT, 32'h10);   rd(v); chk("R8 phase clear keeps ovf", v, w(8'h00, 0, 3'd0, 1));
    cyc(0, 0, 0, 0, 0, 1, STAT, 32'h08);   rd(v); chk("R8 ovf w1c", v, 32'h0);
    cyc(1, 2'd3, 1, 1, 8'h66, 0, STAT, 0); rd(v); chk("R3 re-armed capture", v, w(8'h66, 0, 3'd5, 0));
    corr_dis = 1'b1;
    cyc(1, 2'd0, 0, 0, 8'h01, 0, STAT, 0); rd(v); chk("R7 corr-disabled locked sets ovf", v, w(8'h66, 0, 3'd5, 1));
    corr_dis = 1'b0;
    cyc(0, 0, 0, 0, 0, 1, STAT, 32'h78);   rd(v); chk("R8 clear both", v, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    cyc(1, 2'd2, 0, 0, 8'h44, 0, STAT, 0);
    cyc(1, 2'd0, 0, 1, 8'h99, 1, STAT, 32'h40); rd(v); chk("R9 locked clear wins no ovf", v, 32'h0);
    cyc(1, 2'd1, 0, 1, 8'h99, 1, STAT, 32'h20); rd(v); chk("R9 unlocked event dropped", v, 32'h0);
    cyc(1, 2'd2, 0, 0, 8'h44, 0, STAT, 0);
    cyc(1, 2'd0, 0, 1, 8'h12, 1, STAT, 32'h08); rd(v); chk("R8 set wins over ovf clear", v, w(8'h44, 1, 3'd3, 1));
  endtask

  task automatic t_read();
    logic [31:0] v;
    addr = OTHER; #1 chk("R10 other address reads zero", rdata, 32'h0);
    cyc(0, 0, 0, 0, 0, 1, OTHER, 32'hFFFF_FFFF); rd(v); chk("R10 write elsewhere ignored", v, w(8'h44, 1, 3'd3, 1));
    cyc(0, 0, 0, 0, 0, 1, STAT, 32'h78);        rd(v); chk("R10 final clear", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_encode();
    t_corrected();
    t_lock();
    t_race();
    t_read();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule